// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a real-time clock core attached to a plain 32-bit register bus with select and write strobes. A prescaler divides the 32.768 kHz input clock down to one tick per second, and each tick advances a 32-bit seconds counter while the run bit in the control register is set. Software presets the counter by writing a load register, reads the live count from its own read-only register, and programs a match value.

When a tick brings the counter to the match value, a sticky raw alarm bit is set. A mask bit gates this bit onto a masked status view and onto the single interrupt output. Software acknowledges the alarm by writing a one to a clear register. A load write also restarts the prescaler, so the first increment after a preset always comes one full second later.

Top module: `sec_alarm_rtc`

## Requirements
- R1: After reset, every register reads 0 and irq_o is low.
- R2: A write to offset 0x08 replaces the counter value. From the next cycle, offset 0x00 returns the written value, and offset 0x08 reads back the last value written to it.
- R3: While control bit 26 is set, the counter goes up by one every TICK_DIV clock cycles and wraps from 0xFFFFFFFF to 0.
- R4: While control bit 26 is clear, the counter and the prescaler hold. The control register at 0x0C stores only bit 26 and reads 0 in every other bit.
- R5: A load write restarts the prescaler. With the run bit set, the first increment after the load comes exactly TICK_DIV cycles after it, whatever the prescaler phase was before the load.
- R6: The match register at 0x04 is read/write. Raw status bit 0 at 0x14 is set on the tick where the counter becomes equal to the match value, and not by a load of that value. It stays set while the counter moves on, whatever the mask bit is.
- R7: Mask bit 0 lives at 0x10. The masked status at 0x18 reads raw AND mask in bit 0, and irq_o equals that masked bit.
- R8: Writing 0x1C with bit 0 set clears the raw bit. Writing 0x1C with bit 0 clear leaves the raw bit unchanged. Offset 0x1C reads 0.
- R9: When a clear write and an alarm set fall in the same cycle, the raw bit ends up set.
- R10: Writes to 0x00, 0x14 and 0x18 change nothing. Offsets 0x20 and above, and any address whose two low bits are not zero, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Access strobe |
| bus_wr_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Alarm interrupt, taken from the masked status |

## Verification
The counting path is checked with several load values: zero, all ones, alternating bit patterns, single set bits, and values near the 32-bit wrap. A wrong load width or an early wrap shows up in these readbacks. Each increment is sampled one cycle before and one cycle after its expected edge, which separates a correct prescaler period from one that is off by one cycle. A second load placed in the middle of a prescaler period tells restart apart from free-running.

For the alarm, the bench looks at it first with the mask low and then with it high, and sends clear writes with bit 0 both zero and one. It also times one clear to land on the very edge where the match fires, so set-priority can be told apart from clear-priority. Sweeps over unmapped and unaligned addresses, together with writes to read-only registers, check that no register changes where none should.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned REG_WORDS   = 8;
  localparam int unsigned CTRL_EN_BIT = 26;

  typedef enum logic [2:0] {
    OFS_VALUE = 3'd0,
    OFS_MATCH = 3'd1,
    OFS_LOAD  = 3'd2,
    OFS_CTRL  = 3'd3,
    OFS_MASK  = 3'd4,
    OFS_RAW   = 3'd5,
    OFS_MIS   = 3'd6,
    OFS_CLR   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICK_DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] div_q;
  logic             at_last;

  assign at_last = (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (run_i)     div_q <= at_last ? '0 : div_q + 1'b1;
  end

  // a restart in the same cycle swallows the tick
  assign tick_o = run_i & at_last & ~restart_i;
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] match_val_i,
  output logic [DATA_W-1:0] value_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] value_q;
  logic [DATA_W-1:0] value_nx;

  assign value_nx = value_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     value_q <= '0;
    else if (load_i) value_q <= load_val_i;
    else if (tick_i) value_q <= value_nx;
  end

  assign value_o = value_q;
  assign hit_o   = tick_i & ~load_i & (value_nx == match_val_i);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_we_i,
  input  logic mask_val_i,
  output logic raw_o,
  output logic mask_o,
  output logic irq_o
);
  logic raw_q;
  logic mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      raw_q <= set_i | (raw_q & ~clr_i);
      if (mask_we_i) mask_q <= mask_val_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = raw_q & mask_q;
endmodule

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc #(
  parameter int unsigned TICK_DIV = 32768,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  import rtc_pkg::*;

  logic              hi_zero;
  logic              in_map;
  reg_idx_e          idx;
  logic              wr_en;
  logic              load_we;
  logic              clr_we;
  logic              mask_we;
  logic [DATA_W-1:0] match_q;
  logic [DATA_W-1:0] load_q;
  logic              ctrl_en_q;
  logic              tick;
  logic              set_evt;
  logic [DATA_W-1:0] cnt_value;
  logic              raw_st;
  logic              mask_st;

  if (ADDR_W > 5) begin : g_hi
    assign hi_zero = ~|bus_addr_i[ADDR_W-1:5];
  end else begin : g_nohi
    assign hi_zero = 1'b1;
  end

  assign in_map  = hi_zero & (bus_addr_i[1:0] == 2'b00);
  assign idx     = reg_idx_e'(bus_addr_i[4:2]);
  assign wr_en   = bus_sel_i & bus_wr_i & in_map;
  assign load_we = wr_en & (idx == OFS_LOAD);
  assign clr_we  = wr_en & (idx == OFS_CLR) & bus_wdata_i[0];
  assign mask_we = wr_en & (idx == OFS_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q   <= '0;
      load_q    <= '0;
      ctrl_en_q <= 1'b0;
    end else if (wr_en) begin
      case (idx)
        OFS_MATCH: match_q   <= bus_wdata_i;
        OFS_LOAD:  load_q    <= bus_wdata_i;
        OFS_CTRL:  ctrl_en_q <= bus_wdata_i[CTRL_EN_BIT];
        default:   ;
      endcase
    end
  end

  rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl_en_q),
    .restart_i (load_we),
    .tick_o    (tick)
  );

  rtc_sec_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_we),
    .load_val_i  (bus_wdata_i),
    .tick_i      (tick),
    .match_val_i (match_q),
    .value_o     (cnt_value),
    .hit_o       (set_evt)
  );

  rtc_alarm_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_evt),
    .clr_i      (clr_we),
    .mask_we_i  (mask_we),
    .mask_val_i (bus_wdata_i[0]),
    .raw_o      (raw_st),
    .mask_o     (mask_st),
    .irq_o      (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (in_map) begin
      case (idx)
        OFS_VALUE: bus_rdata_o = cnt_value;
        OFS_MATCH: bus_rdata_o = match_q;
        OFS_LOAD:  bus_rdata_o = load_q;
        OFS_CTRL:  bus_rdata_o[CTRL_EN_BIT] = ctrl_en_q;
        OFS_MASK:  bus_rdata_o[0] = mask_st;
        OFS_RAW:   bus_rdata_o[0] = raw_st;
        OFS_MIS:   bus_rdata_o[0] = irq_o;
        default:   bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_we,
  input logic [DATA_W-1:0] load_val,
  input logic              ctrl_en,
  input logic [DATA_W-1:0] value,
  input logic              set_evt,
  input logic              clr_we,
  input logic              raw,
  input logic              mask,
  input logic              irq_o
);
  a_r2_load_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we |=> value == $past(load_val));

  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_we |=> (value == $past(value)) || (value == $past(value) + 1'b1));

  a_r4_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en && !load_we) |=> value == $past(value));

  a_r6_raw_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw && !clr_we) |=> raw);

  a_r7_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw && mask));

  a_r7_irq_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw && mask) |-> irq_o);

  a_r8_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we && !set_evt) |=> !raw);

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> raw);
endmodule

bind sec_alarm_rtc rtc_alarm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_we  (load_we),
  .load_val (bus_wdata_i),
  .ctrl_en  (ctrl_en_q),
  .value    (cnt_value),
  .set_evt  (set_evt),
  .clr_we   (clr_we),
  .raw      (raw_st),
  .mask     (mask_st),
  .irq_o    (irq_o)
);

// File: tb/sec_alarm_rtc_test.sv
`timescale 1ns/1ps
module sec_alarm_rtc_test;
  localparam int unsigned DIV = 4;
  localparam logic [31:0] EN = 32'h1 << 26;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          tests = 0;
  int          fails = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  sec_alarm_rtc #(.TICK_DIV(DIV), .DATA_W(32), .ADDR_W(6)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bw(input logic [5:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic br(input logic [5:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    br(a, v);
    check(tag, v, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] pats [6];
    logic [31:0] bases [3];
    pats  = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0000_0001, 32'h8000_0000};
    bases = '{32'h0000_0010, 32'hFFFF_FFFE, 32'h7FFF_FFFF};

    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) expect_rd("R1", 6'(i * 4), 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) expect_rd("R1", 6'(i * 4), 32'h0);

    // R2 load patterns, R4 hold while stopped
    for (int k = 0; k < 6; k++) begin
      bw(6'h08, pats[k]);
      expect_rd("R2 value", 6'h00, pats[k]);
      expect_rd("R2 load readback", 6'h08, pats[k]);
      repeat (3 * DIV) @(negedge clk);
      expect_rd("R4 hold", 6'h00, pats[k]);
    end

    // R4 only bit 26 of control is stored
    bw(6'h0C, ~EN);
    expect_rd("R4 ctrl bits", 6'h0C, 32'h0);
    bw(6'h08, 32'h55);
    repeat (3 * DIV) @(negedge clk);
    expect_rd("R4 hold", 6'h00, 32'h55);
    bw(6'h0C, EN);
    expect_rd("R4 ctrl en", 6'h0C, EN);

    // R3 counting, wrap; R5 increment period measured from the load
    for (int b = 0; b < 3; b++) begin
      bw(6'h08, bases[b]);
      for (int k = 1; k <= 3; k++) begin
        repeat (DIV - 1) @(negedge clk);
        expect_rd("R5 before tick", 6'h00, bases[b] + 32'(k - 1));
        @(negedge clk);
        expect_rd("R3 after tick", 6'h00, bases[b] + 32'(k));
      end
    end

    // R5 reload in the middle of a prescaler period
    bw(6'h08, 32'd100);
    repeat (DIV - 2) @(negedge clk);
    bw(6'h08, 32'd200);
    repeat (DIV - 1) @(negedge clk);
    expect_rd("R5 restart", 6'h00, 32'd200);
    @(negedge clk);
    expect_rd("R5 restart", 6'h00, 32'd201);

    // R4 stop mid run
    bw(6'h0C, 32'h0);
    begin
      logic [31:0] held;
      br(6'h00, held);
      repeat (3 * DIV) @(negedge clk);
      expect_rd("R4 stopped", 6'h00, held);
    end
    bw(6'h0C, EN);

    // R6 alarm with mask off
    bw(6'h1C, 32'h1);
    bw(6'h10, 32'h0);
    bw(6'h04, 32'd503);
    expect_rd("R6 match rw", 6'h04, 32'd503);
    bw(6'h08, 32'd500);
    repeat (3 * DIV - 1) @(negedge clk);
    expect_rd("R6 before match", 6'h14, 32'h0);
    @(negedge clk);
    expect_rd("R6 at match", 6'h00, 32'd503);
    expect_rd("R6 raw set", 6'h14, 32'h1);
    expect_rd("R7 masked off", 6'h18, 32'h0);
    check("R7 irq off", {31'b0, irq}, 32'h0);
    repeat (2 * DIV) @(negedge clk);
    expect_rd("R6 sticky", 6'h14, 32'h1);

    // R7 mask on
    bw(6'h10, 32'h1);
    expect_rd("R7 mask rw", 6'h10, 32'h1);
    expect_rd("R7 masked on", 6'h18, 32'h1);
    check("R7 irq on", {31'b0, irq}, 32'h1);

    // R8 clear
    bw(6'h1C, 32'h0);
    expect_rd("R8 zero no effect", 6'h14, 32'h1);
    bw(6'h1C, 32'hFFFF_FFFE);
    expect_rd("R8 bit0 clear no effect", 6'h14, 32'h1);
    bw(6'h1C, 32'h1);
    expect_rd("R8 cleared", 6'h14, 32'h0);
    check("R8 irq low", {31'b0, irq}, 32'h0);
    expect_rd("R8 clr reads 0", 6'h1C, 32'h0);

    // R6 loading the match value does not set the alarm
    bw(6'h04, 32'd600);
    bw(6'h08, 32'd600);
    expect_rd("R6 load no set", 6'h14, 32'h0);

    // R9 clear on the same edge as the match
    bw(6'h04, 32'd701);
    bw(6'h08, 32'd700);
    repeat (DIV - 1) @(negedge clk);
    bw(6'h1C, 32'h1);
    expect_rd("R9 count", 6'h00, 32'd701);
    expect_rd("R9 set wins", 6'h14, 32'h1);
    check("R9 irq", {31'b0, irq}, 32'h1);

    // R10 read-only, unmapped, unaligned
    bw(6'h1C, 32'h1);
    bw(6'h0C, 32'h0);
    bw(6'h08, 32'h1234);
    bw(6'h00, 32'hFFFF_FFFF);
    expect_rd("R10 value ro", 6'h00, 32'h1234);
    bw(6'h14, 32'h1);
    expect_rd("R10 raw ro", 6'h14, 32'h0);
    bw(6'h18, 32'h1);
    expect_rd("R10 masked ro", 6'h18, 32'h0);
    check("R10 irq", {31'b0, irq}, 32'h0);
    bw(6'h24, 32'hDEAD_BEEF);
    bw(6'h05, 32'hDEAD_BEEF);
    bw(6'h09, 32'hDEAD_BEEF);
    expect_rd("R10 match kept", 6'h04, 32'd701);
    expect_rd("R10 value kept", 6'h00, 32'h1234);
    for (int i = 8; i < 16; i++) expect_rd("R10 unmapped", 6'(i * 4), 32'h0);
    for (int i = 0; i < 32; i++)
      if ((i % 4) != 0) expect_rd("R10 unaligned", 6'(i), 32'h0);

    finish_run();
  end
endmodule